// File: doc/BRIEF.md
# Dual-Stage MAC with Interlock

This block is a multiply-accumulate datapath built as two execute stages. The multiplier runs in the first stage. The second stage adds the product to, or subtracts it from, one of several wide accumulators. A new MAC operation can enter on every clock. An operation may take its first multiplier operand from the high word of an accumulator instead of from the input bus. When that accumulator is the destination of the operation sitting in stage one, its value is not written yet. The block then raises a bubble indication for that cycle and lets a no-operation pass down the pipe in place of the operation. The issuing side presents the same operation again on the next clock, and it is accepted then. The issuer never has to predict the dependency.

Each operation carries a condition code. The code is tested in stage two against the flags left by the last operation that actually executed. A false condition turns the operation into a no-operation. Besides the full 24-bit multiply there is a 16-bit mode. It multiplies the upper halves of the operands and rounds the accumulated result to 16 significant bits in hardware. The accumulators and the flags can be read at any time through a combinational read port.

Top module: `dual_stage_mac`

## Requirements
- R1: After reset every accumulator reads zero, the flags read zero and no bubble is signalled.
- R2: In full mode the product is the signed 24x24 product of op_x and op_y, sign-extended to 56 bits. Opcode 0 loads the product into op_dst, 1 adds it to op_dst, 2 subtracts it from op_dst, and 3 clears op_dst.
- R3: An operation accepted at clock edge E moves to stage two at E+1 and updates its accumulator at E+2. The read port shows the old value before E+2. Operations without a dependency are accepted on consecutive clocks with no bubble.
- R4: op_bubble is high in the same cycle exactly when op_valid=1, op_xacc=1 and op_src equals the destination of the operation accepted at the immediately preceding edge. A bubbled operation is not accepted.
- R5: When op_xacc=1, the first multiplier operand is bits 47:24 of accumulator op_src. The issuer repeats a bubbled operation unchanged on the next clock. That repeat is accepted, and it reads the value written by the operation it depended on.
- R6: op_cond is tested against the current flags: 0 always, 1 Z set, 2 Z clear, 3 N set, 4 N clear, 5 V set, 6 V clear, 7 never. When the test fails, no accumulator and no flag changes.
- R7: An executed operation sets the flags from its 56-bit result: flags[0] Z is set when the result is zero, flags[1] N is bit 55, and flags[2] V is set when bits 55:47 are not all equal.
- R8: With op_half=1, the signed product of bits 23:8 of both operands is shifted left by 16. After the accumulate, the result is rounded at bit 32 by adding 2^31 and clearing bits 31:0, so ties round upward.
- R9: rd_data shows accumulator rd_sel combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 2 | 0 load, 1 add, 2 subtract, 3 clear |
| op_cond | input | 3 | Condition code, see R6 |
| op_half | input | 1 | Selects 16-bit mode with rounding |
| op_dst | input | 2 | Destination accumulator |
| op_xacc | input | 1 | Take the first operand from an accumulator high word |
| op_src | input | 2 | Accumulator supplying the first operand |
| op_x | input | 24 | First operand from the bus |
| op_y | input | 24 | Second operand |
| op_bubble | output | 1 | Dependency found, operation not taken this cycle |
| rd_sel | input | 2 | Accumulator select for the read port |
| rd_data | output | 56 | Selected accumulator |
| flags | output | 3 | {V, N, Z} |

## Verification
The assertions assume that after every bubble the issuer presents the same operation again on the next clock, with all fields unchanged. The bench's issue routine enforces this: it holds every field and retries whenever it sees the bubble. The other assertions rely only on internal stage state. Their one input assumption is that rd_sel and the operation fields never carry an accumulator index beyond NACC-1. With a power-of-two NACC, which elaboration enforces, every such index is in range. The bench then sweeps operand and opcode grids, every source/destination pair back to back and with a gap, and every condition code against four flag states.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [1:0] {
      OP_MPY  = 2'd0,
      OP_MAC  = 2'd1,
      OP_MSUB = 2'd2,
      OP_CLR  = 2'd3
   } mac_op_e;

   typedef enum logic [2:0] {
      CC_AL = 3'd0,
      CC_ZS = 3'd1,
      CC_ZC = 3'd2,
      CC_NS = 3'd3,
      CC_NC = 3'd4,
      CC_VS = 3'd5,
      CC_VC = 3'd6,
      CC_NV = 3'd7
   } mac_cc_e;

   localparam int FLG_Z = 0;
   localparam int FLG_N = 1;
   localparam int FLG_V = 2;
   localparam int FLG_W = 3;

   function automatic logic cc_pass(input mac_cc_e cc, input logic [FLG_W-1:0] f);
      logic ok;
      unique case (cc)
         CC_AL:   ok = 1'b1;
         CC_ZS:   ok = f[FLG_Z];
         CC_ZC:   ok = !f[FLG_Z];
         CC_NS:   ok = f[FLG_N];
         CC_NC:   ok = !f[FLG_N];
         CC_VS:   ok = f[FLG_V];
         CC_VC:   ok = !f[FLG_V];
         default: ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/mac_interlock.sv
module mac_interlock #(
   parameter int AIW = 2
) (
   input  logic           req_valid,
   input  logic           req_xacc,
   input  logic [AIW-1:0] req_src,
   input  logic           s1_valid,
   input  logic [AIW-1:0] s1_dst,
   output logic           bubble,
   output logic           issue
);

   logic dep_hit;

   // a result still in stage one is written only at the end of stage two,
   // so an operand read in stage one cannot see it yet
   assign dep_hit = req_xacc && s1_valid && (req_src == s1_dst);
   assign bubble  = req_valid && dep_hit;
   assign issue   = req_valid && !dep_hit;

endmodule

// File: rtl/mac_mul_stage.sv
module mac_mul_stage #(
   parameter int DW   = 24,
   parameter int HW   = 16,
   parameter int GW   = 8,
   parameter int NACC = 4,
   parameter int AIW  = 2,
   parameter int AW   = GW + 2 * DW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [1:0]        in_code,
   input  logic [2:0]        in_cond,
   input  logic              in_half,
   input  logic [AIW-1:0]    in_dst,
   input  logic              in_xacc,
   input  logic [AIW-1:0]    in_src,
   input  logic [DW-1:0]     in_x,
   input  logic [DW-1:0]     in_y,
   input  logic [NACC*DW-1:0] acc_hi,
   output logic              s1_valid,
   output logic [AIW-1:0]    s1_dst,
   output logic [1:0]        s1_code,
   output logic [2:0]        s1_cond,
   output logic              s1_half,
   output logic [AW-1:0]     prod
);

   localparam int PW = 2 * DW;

   logic           s1_xacc;
   logic [AIW-1:0] s1_src;
   logic [DW-1:0]  s1_x;
   logic [DW-1:0]  s1_y;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_valid <= 1'b0;
         s1_dst   <= '0;
         s1_code  <= '0;
         s1_cond  <= '0;
         s1_half  <= 1'b0;
         s1_xacc  <= 1'b0;
         s1_src   <= '0;
         s1_x     <= '0;
         s1_y     <= '0;
      end else begin
         s1_valid <= issue;
         if (issue) begin
            s1_dst  <= in_dst;
            s1_code <= in_code;
            s1_cond <= in_cond;
            s1_half <= in_half;
            s1_xacc <= in_xacc;
            s1_src  <= in_src;
            s1_x    <= in_x;
            s1_y    <= in_y;
         end
      end
   end

   // operand select happens here, one stage after issue
   logic [DW-1:0] xe;
   assign xe = s1_xacc ? acc_hi[s1_src*DW +: DW] : s1_x;

   logic signed [PW-1:0] fx, fy, fp;
   assign fx = {{DW{xe[DW-1]}}, xe};
   assign fy = {{DW{s1_y[DW-1]}}, s1_y};
   assign fp = fx * fy;

   generate
      if (HW < DW) begin : g_half
         logic signed [2*HW-1:0] hx, hy, hp;
         logic [PW-1:0]          hsh;
         assign hx   = {{HW{xe[DW-1]}}, xe[DW-1 -: HW]};
         assign hy   = {{HW{s1_y[DW-1]}}, s1_y[DW-1 -: HW]};
         assign hp   = hx * hy;
         assign hsh  = {hp, {(2*(DW-HW)){1'b0}}};
         assign prod = s1_half ? {{GW{hsh[PW-1]}}, hsh} : {{GW{fp[PW-1]}}, fp};
      end else begin : g_full
         assign prod = {{GW{fp[PW-1]}}, fp};
      end
   endgenerate

endmodule

// File: rtl/mac_acc_stage.sv
module mac_acc_stage
   import mac_pkg::*;
#(
   parameter int DW   = 24,
   parameter int HW   = 16,
   parameter int GW   = 8,
   parameter int NACC = 4,
   parameter int AIW  = 2,
   parameter int AW   = GW + 2 * DW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [AIW-1:0]      in_dst,
   input  logic [1:0]          in_code,
   input  logic [2:0]          in_cond,
   input  logic                in_half,
   input  logic [AW-1:0]       in_prod,
   output logic                s2_valid,
   output logic [NACC*AW-1:0]  acc_flat,
   output logic [FLG_W-1:0]    flags
);

   localparam int RND = 2 * DW - HW;

   logic [AIW-1:0] s2_dst;
   logic [1:0]     s2_code;
   logic [2:0]     s2_cond;
   logic           s2_half;
   logic [AW-1:0]  s2_prod;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_valid <= 1'b0;
         s2_dst   <= '0;
         s2_code  <= '0;
         s2_cond  <= '0;
         s2_half  <= 1'b0;
         s2_prod  <= '0;
      end else begin
         s2_valid <= in_valid;
         if (in_valid) begin
            s2_dst  <= in_dst;
            s2_code <= in_code;
            s2_cond <= in_cond;
            s2_half <= in_half;
            s2_prod <= in_prod;
         end
      end
   end

   logic [NACC-1:0][AW-1:0] acc_q;
   logic [FLG_W-1:0]        flg_q, flg_d;
   logic [AW-1:0]           cur, raw, fin;
   logic                    pass, exec;

   assign cur = acc_q[s2_dst];

   always_comb begin
      unique case (mac_op_e'(s2_code))
         OP_MPY:  raw = s2_prod;
         OP_MAC:  raw = cur + s2_prod;
         OP_MSUB: raw = cur - s2_prod;
         default: raw = '0;
      endcase
   end

   generate
      if (HW < DW) begin : g_rnd
         localparam logic [AW-1:0] LOWMASK = (AW'(1) << RND) - AW'(1);
         localparam logic [AW-1:0] HALFLSB = AW'(1) << (RND - 1);
         logic [AW-1:0] sum_r;
         assign sum_r = raw + HALFLSB;
         assign fin   = s2_half ? (sum_r & ~LOWMASK) : raw;

         // R8
         half_round_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (exec && s2_half) |=> ((acc_q[$past(s2_dst)] & LOWMASK) == '0));
      end else begin : g_nornd
         assign fin = raw;
      end
   endgenerate

   logic [GW:0] grd;
   assign grd = fin[AW-1 -: GW+1];

   always_comb begin
      flg_d        = '0;
      flg_d[FLG_Z] = (fin == '0);
      flg_d[FLG_N] = fin[AW-1];
      flg_d[FLG_V] = !((&grd) || !(|grd));
   end

   assign pass = cc_pass(mac_cc_e'(s2_cond), flg_q);
   assign exec = s2_valid && pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         flg_q <= '0;
      end else if (exec) begin
         for (int i = 0; i < NACC; i++) begin
            if (s2_dst == AIW'(i)) acc_q[i] <= fin;
         end
         flg_q <= flg_d;
      end
   end

   assign acc_flat = acc_q;
   assign flags    = flg_q;

   // R6
   false_cond_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (s2_valid && !pass) |=> ($stable(acc_q) && $stable(flg_q)));

endmodule

// File: rtl/dual_stage_mac.sv
module dual_stage_mac
   import mac_pkg::*;
#(
   parameter int  DW   = 24,
   parameter int  HW   = 16,
   parameter int  GW   = 8,
   parameter int  NACC = 4,
   localparam int AIW  = $clog2(NACC),
   localparam int AW   = GW + 2 * DW
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           op_valid,
   input  logic [1:0]     op_code,
   input  logic [2:0]     op_cond,
   input  logic           op_half,
   input  logic [AIW-1:0] op_dst,
   input  logic           op_xacc,
   input  logic [AIW-1:0] op_src,
   input  logic [DW-1:0]  op_x,
   input  logic [DW-1:0]  op_y,
   output logic           op_bubble,
   input  logic [AIW-1:0] rd_sel,
   output logic [AW-1:0]  rd_data,
   output logic [2:0]     flags
);

   initial begin
      assert (HW >= 2 && HW <= DW) else $error("HW must lie in 2..DW");
      assert (NACC >= 2 && (1 << AIW) == NACC) else $error("NACC must be a power of two >= 2");
      assert (GW >= 1) else $error("GW must be at least 1");
   end

   logic               issue;
   logic               s1_valid, s1_half, s2_valid;
   logic [AIW-1:0]     s1_dst;
   logic [1:0]         s1_code;
   logic [2:0]         s1_cond;
   logic [AW-1:0]      prod;
   logic [NACC*AW-1:0] acc_flat;
   logic [NACC*DW-1:0] acc_hi;

   generate
      for (genvar i = 0; i < NACC; i++) begin : g_hi
         assign acc_hi[i*DW +: DW] = acc_flat[i*AW + DW +: DW];
      end
   endgenerate

   mac_interlock #(.AIW(AIW)) u_lock (
      .req_valid (op_valid),
      .req_xacc  (op_xacc),
      .req_src   (op_src),
      .s1_valid  (s1_valid),
      .s1_dst    (s1_dst),
      .bubble    (op_bubble),
      .issue     (issue)
   );

   mac_mul_stage #(.DW(DW), .HW(HW), .GW(GW), .NACC(NACC), .AIW(AIW), .AW(AW)) u_mul (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue),
      .in_code  (op_code),
      .in_cond  (op_cond),
      .in_half  (op_half),
      .in_dst   (op_dst),
      .in_xacc  (op_xacc),
      .in_src   (op_src),
      .in_x     (op_x),
      .in_y     (op_y),
      .acc_hi   (acc_hi),
      .s1_valid (s1_valid),
      .s1_dst   (s1_dst),
      .s1_code  (s1_code),
      .s1_cond  (s1_cond),
      .s1_half  (s1_half),
      .prod     (prod)
   );

   mac_acc_stage #(.DW(DW), .HW(HW), .GW(GW), .NACC(NACC), .AIW(AIW), .AW(AW)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (s1_valid),
      .in_dst   (s1_dst),
      .in_code  (s1_code),
      .in_cond  (s1_cond),
      .in_half  (s1_half),
      .in_prod  (prod),
      .s2_valid (s2_valid),
      .acc_flat (acc_flat),
      .flags    (flags)
   );

   assign rd_data = acc_flat[rd_sel*AW +: AW];

   // R4
   bubble_blocks_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_bubble |=> !s1_valid);

   // R3
   stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s1_valid |=> s2_valid);

   // R5
   reissue_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_bubble |=> (op_valid && op_xacc && $stable(op_src) && $stable(op_dst) &&
                     $stable(op_code) && $stable(op_cond) && $stable(op_half) &&
                     $stable(op_x) && $stable(op_y)));

endmodule

// File: tb/sim_dual_stage_mac.sv
module sim_dual_stage_mac;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = '0;
   logic [2:0]  op_cond = '0;
   logic        op_half = 1'b0;
   logic [1:0]  op_dst = '0;
   logic        op_xacc = 1'b0;
   logic [1:0]  op_src = '0;
   logic [23:0] op_x = '0;
   logic [23:0] op_y = '0;
   logic        op_bubble;
   logic [1:0]  rd_sel = '0;
   logic [55:0] rd_data;
   logic [2:0]  flags;

   always #5 clk = ~clk;

   dual_stage_mac u0 (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_cond(op_cond), .op_half(op_half), .op_dst(op_dst), .op_xacc(op_xacc),
      .op_src(op_src), .op_x(op_x), .op_y(op_y), .op_bubble(op_bubble),
      .rd_sel(rd_sel), .rd_data(rd_data), .flags(flags)
   );

   int          n_chk = 0;
   int          n_err = 0;
   int          n_bub = 0;
   bit          done = 1'b0;
   logic [55:0] m_acc [4];
   logic [2:0]  m_flg;
   logic        pv;
   logic [1:0]  pd;
   logic [23:0] vals [6];
   logic [23:0] hv [6];
   logic [55:0] old0;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic cpass(input logic [2:0] cc, input logic [2:0] f);
      case (cc)
         3'd0: return 1'b1;
         3'd1: return f[0];
         3'd2: return !f[0];
         3'd3: return f[1];
         3'd4: return !f[1];
         3'd5: return f[2];
         3'd6: return !f[2];
         default: return 1'b0;
      endcase
   endfunction

   task automatic model_exec(input logic [1:0] code, input logic [2:0] cc, input logic half,
                             input logic [1:0] dst, input logic xacc, input logic [1:0] src,
                             input logic [23:0] x, input logic [23:0] y);
      logic [23:0]        xv;
      logic signed [47:0] xs, ys, p48;
      logic signed [31:0] hx, hy, p32;
      logic [55:0]        p, r;
      xv = xacc ? m_acc[src][47:24] : x;
      if (!half) begin
         xs  = {{24{xv[23]}}, xv};
         ys  = {{24{y[23]}}, y};
         p48 = xs * ys;
      end else begin
         hx  = {{16{xv[23]}}, xv[23:8]};
         hy  = {{16{y[23]}}, y[23:8]};
         p32 = hx * hy;
         p48 = {p32, 16'h0000};
      end
      p = {{8{p48[47]}}, p48};
      case (code)
         2'd0: r = p;
         2'd1: r = m_acc[dst] + p;
         2'd2: r = m_acc[dst] - p;
         default: r = '0;
      endcase
      if (half) begin
         r = r + 56'h0000_0080_000000;
         r[31:0] = '0;
      end
      if (cpass(cc, m_flg)) begin
         m_acc[dst] = r;
         m_flg[0] = (r == '0);
         m_flg[1] = r[55];
         m_flg[2] = !((r[55:47] == 9'h000) || (r[55:47] == 9'h1FF));
      end
   endtask

   // drives one operation, repeating it unchanged after a bubble
   task automatic issue(input logic [1:0] code, input logic [2:0] cc, input logic half,
                        input logic [1:0] dst, input logic xacc, input logic [1:0] src,
                        input logic [23:0] x, input logic [23:0] y);
      logic exp_b;
      for (int t = 0; t < 3; t++) begin
         @(negedge clk);
         op_valid = 1'b1; op_code = code; op_cond = cc; op_half = half;
         op_dst = dst; op_xacc = xacc; op_src = src; op_x = x; op_y = y;
         #1;
         exp_b = xacc && pv && (src == pd);
         chk("R4", {63'd0, op_bubble}, {63'd0, exp_b});
         if (op_bubble) begin
            n_bub++;
            pv = 1'b0;
         end else begin
            model_exec(code, cc, half, dst, xacc, src, x, y);
            pv = 1'b1;
            pd = dst;
            break;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         op_valid = 1'b0;
         op_xacc  = 1'b0;
         pv = 1'b0;
      end
   endtask

   task automatic drain_check(input string tag);
      idle(3);
      for (int i = 0; i < 4; i++) begin
         rd_sel = 2'(i);
         #1;
         chk(tag, {8'd0, rd_data}, {8'd0, m_acc[i]});
      end
      chk("R7", {61'd0, flags}, {61'd0, m_flg});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog R1: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 4; i++) m_acc[i] = '0;
      m_flg = '0;
      pv = 1'b0;
      pd = '0;
      vals[0] = 24'h000000; vals[1] = 24'h000001; vals[2] = 24'hFFFFFF;
      vals[3] = 24'h7FFFFF; vals[4] = 24'h800000; vals[5] = 24'h123456;
      hv[0] = 24'h008000; hv[1] = 24'h010000; hv[2] = 24'hFFFFFF;
      hv[3] = 24'h7FFFFF; hv[4] = 24'h800000; hv[5] = 24'h12345F;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1", {63'd0, op_bubble}, 64'd0);
      for (int i = 0; i < 4; i++) begin
         rd_sel = 2'(i);
         #1;
         chk("R1", {8'd0, rd_data}, 64'd0);
      end
      chk("R1", {61'd0, flags}, 64'd0);

      // R2 full-mode opcode and operand grid
      for (int c = 0; c < 4; c++) begin
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               issue(2'(c), 3'd0, 1'b0, 2'(i + j), 1'b0, 2'd0, vals[i], vals[j]);
         drain_check("R2");
      end

      // R3 latency: old value until the second edge after acceptance
      old0 = m_acc[0];
      issue(2'd0, 3'd0, 1'b0, 2'd0, 1'b0, 2'd0, 24'h000005, 24'h000007);
      rd_sel = 2'd0;
      idle(1); #1;
      chk("R3", {8'd0, rd_data}, {8'd0, old0});
      idle(1); #1;
      chk("R3", {8'd0, rd_data}, {8'd0, old0});
      idle(1); #1;
      chk("R3", {8'd0, rd_data}, 64'd35);

      // R3 throughput: back-to-back accumulation, no bubbles expected
      n_bub = 0;
      issue(2'd0, 3'd0, 1'b0, 2'd1, 1'b0, 2'd0, 24'h000002, 24'h000003);
      for (int k = 0; k < 8; k++)
         issue(2'd1, 3'd0, 1'b0, 2'd1, 1'b0, 2'd0, 24'(k + 1), 24'h000003);
      chk("R3", 64'(n_bub), 64'd0);
      drain_check("R3");

      // R4 / R5 every source/destination pair, adjacent and with a gap
      for (int d = 0; d < 4; d++) begin
         for (int s = 0; s < 4; s++) begin
            issue(2'd0, 3'd0, 1'b0, 2'(d), 1'b0, 2'd0, 24'(24'h010000 * (d + 1)), 24'h000100);
            issue(2'd1, 3'd0, 1'b0, 2'(d + 1), 1'b1, 2'(s), 24'h0, 24'h000003);
            issue(2'd0, 3'd0, 1'b0, 2'(d), 1'b0, 2'd0, 24'h000011, 24'h000100);
            idle(1);
            issue(2'd2, 3'd0, 1'b0, 2'(s + 2), 1'b1, 2'(d), 24'h0, 24'h000005);
            issue(2'd1, 3'd0, 1'b0, 2'(d + 3), 1'b0, 2'(s + 2), 24'h000009, 24'h000002);
         end
         drain_check("R5");
      end

      // R6 / R7 every condition against zero, negative, positive, overflow
      for (int st = 0; st < 4; st++) begin
         for (int cc = 0; cc < 8; cc++) begin
            case (st)
               0: issue(2'd0, 3'd0, 1'b0, 2'd3, 1'b0, 2'd0, 24'h000000, 24'h000005);
               1: issue(2'd0, 3'd0, 1'b0, 2'd3, 1'b0, 2'd0, 24'h000001, 24'hFFFFFF);
               2: issue(2'd0, 3'd0, 1'b0, 2'd3, 1'b0, 2'd0, 24'h000001, 24'h000001);
               default: begin
                  issue(2'd0, 3'd0, 1'b0, 2'd3, 1'b0, 2'd0, 24'h800000, 24'h800000);
                  issue(2'd1, 3'd0, 1'b0, 2'd3, 1'b0, 2'd0, 24'h800000, 24'h800000);
               end
            endcase
            issue(2'd1, 3'(cc), 1'b0, 2'd2, 1'b0, 2'd0, 24'h000003, 24'h000005);
            drain_check("R6");
         end
      end

      // R8 half mode grid with rounding
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 6; j++)
            issue(((i + j) % 2 == 1) ? 2'd1 : 2'd0, 3'd0, 1'b1, 2'(i), 1'b0, 2'd0, hv[i], hv[j]);
         drain_check("R8");
      end
      issue(2'd0, 3'd0, 1'b1, 2'd0, 1'b0, 2'd0, 24'h008000, 24'h010000);
      drain_check("R8");
      rd_sel = 2'd0;
      #1;
      chk("R8", {8'd0, rd_data}, 64'h0000_0001_0000_0000);

      // R9 distinct value in every accumulator, read each back
      for (int i = 0; i < 4; i++)
         issue(2'd0, 3'd0, 1'b0, 2'(i), 1'b0, 2'd0, 24'(i * 7 + 3), 24'h000101);
      drain_check("R9");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule